// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a bus-attached general-purpose I/O controller for up to 31 pins. Software reaches it through a simple 32-bit register port with a combinational read path and single-cycle writes. Outputs are changed with write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. A direction register drives the pad output-enables. A build-time parameter can reverse its meaning so that a 1 selects input. Pad inputs are brought through a two-stage synchronizer before software or the interrupt logic sees them.

Each pin has its own interrupt detector. The type register chooses level or edge, and the polarity register chooses the active level or edge direction. A pin reports pending only while its enable bit is set. Reporting to the single combined interrupt output also needs the mask bit. Latched edges are acknowledged by writing ones to the pending register. Clearing a pin's enable drops any latched edge, so software can disable a pin, rewrite its type and polarity, and re-enable it without a stale event firing. Both-edge detection by toggling polarity is done by software.

Top module: `gpio_intc`

## Requirements
- R1: After reset all registers read 0, `pad_out` is 0, `irq` is 0, and `pad_oe` is all zeros (all ones when `INV_DIR`=1).
- R2: Byte offsets: 0x00 direction, 0x04 input, 0x0C set, 0x10 clear, 0x14 interrupt enable, 0x18 interrupt type, 0x1C interrupt polarity, 0x20 pending, 0x24 interrupt mask.
- R3: A 1 written to a bit of the set register makes that output 1. A 1 written to the clear register makes it 0. Zero bits leave outputs unchanged. Reading either register returns the current `pad_out`.
- R4: With `INV_DIR`=0 `pad_oe` equals the direction register. With `INV_DIR`=1 it is its bitwise inverse. The direction register reads back as written.
- R5: The input register returns `pad_in` through two flops: a change driven before clock edge k is readable after edge k+1 and not after edge k.
- R6: Type bit 1 selects level detection. The pending bit of an enabled pin is 1 while its synchronized input equals its polarity bit.
- R7: Type bit 0 selects edge detection: polarity 1 = rising, 0 = falling. A detected edge latches the pending bit, which stays set after the input returns and clears when a 1 is written to that pending bit.
- R8: `irq` is 1 exactly when some pin has pending, enable and mask bits all 1. A pending pin with mask 0, or with enable 0, does not raise `irq`.
- R9: Edges arriving while a pin is disabled are not recorded. Clearing the enable bit discards a latched edge. Rewriting polarity or type with a steady input never creates an edge event.
- R10: `PIN_CNT` must be below 32. Register bits at and above `PIN_CNT` read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1 together with `bus_en` |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | PIN_CNT | Pad input levels, asynchronous |
| pad_out | output | PIN_CNT | Pad output levels |
| pad_oe | output | PIN_CNT | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is a change of configuration on a live pin. This means an edge that arrives while the pin is disabled, a latched edge followed by a disable and re-enable, and a polarity or type rewrite under a steady input. The bench builds each of these with exact cycle placement of `pad_in` changes relative to register writes. It then checks that pending and `irq` stay low. Every pin is swept through both detection types and both polarities with one pin active at a time, so crosstalk between pins would also show.

// File: rtl/gpio_intc_pkg.sv
package gpio_intc_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IN    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ITYPE = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IPOL  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_IPEND = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IMASK = 8'h24;
endpackage

// File: rtl/gpio_intc_sync.sv
module gpio_intc_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/gpio_intc_detect.sv
module gpio_intc_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] smp,
  input  logic [WIDTH-1:0] ien,
  input  logic [WIDTH-1:0] itype,
  input  logic [WIDTH-1:0] ipol,
  input  logic             ack_we,
  input  logic [WIDTH-1:0] ack,
  output logic [WIDTH-1:0] pend
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] edge_q;
  logic [WIDTH-1:0] edge_d;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] lvl;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      hit[i] = ipol[i] ? (smp[i] & ~prev_q[i]) : (~smp[i] & prev_q[i]);
      lvl[i] = ien[i] & itype[i] & ~(smp[i] ^ ipol[i]);
      if (!ien[i] || itype[i]) begin
        edge_d[i] = 1'b0;
      end else if (hit[i]) begin
        edge_d[i] = 1'b1;
      end else if (ack_we && ack[i]) begin
        edge_d[i] = 1'b0;
      end else begin
        edge_d[i] = edge_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= smp;
      edge_q <= edge_d;
    end
  end

  assign pend = lvl | (edge_q & ien & ~itype);

  // R9: a pin seen disabled never holds a latched edge one cycle later
  p_disable_drops_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & ~$past(ien)) == '0));
endmodule

// File: rtl/gpio_intc.sv
module gpio_intc
  import gpio_intc_pkg::*;
#(
  parameter int unsigned PIN_CNT = 8,
  parameter bit          INV_DIR = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [PIN_CNT-1:0] pad_in,
  output logic [PIN_CNT-1:0] pad_out,
  output logic [PIN_CNT-1:0] pad_oe,
  output logic               irq
);
  localparam int unsigned N = PIN_CNT;

  logic [N-1:0] dir_q,  dir_d;
  logic [N-1:0] out_q,  out_d;
  logic [N-1:0] ien_q,  ien_d;
  logic [N-1:0] ityp_q, ityp_d;
  logic [N-1:0] ipol_q, ipol_d;
  logic [N-1:0] imsk_q, imsk_d;
  logic [N-1:0] smp;
  logic [N-1:0] pend;
  logic [N-1:0] wd;
  logic [N-1:0] rd_v;
  logic         wr;
  logic         ack_we;

  assign wr     = bus_en & bus_we;
  assign wd     = bus_wdata[N-1:0];
  assign ack_we = wr && (bus_addr == OFS_IPEND);

  gpio_intc_sync #(.WIDTH(N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (smp)
  );

  gpio_intc_detect #(.WIDTH(N)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp    (smp),
    .ien    (ien_q),
    .itype  (ityp_q),
    .ipol   (ipol_q),
    .ack_we (ack_we),
    .ack    (wd),
    .pend   (pend)
  );

  // next-state
  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    ien_d  = ien_q;
    ityp_d = ityp_q;
    ipol_d = ipol_q;
    imsk_d = imsk_q;
    if (wr) begin
      unique case (bus_addr)
        OFS_DIR:   dir_d  = wd;
        OFS_SET:   out_d  = out_q | wd;
        OFS_CLR:   out_d  = out_q & ~wd;
        OFS_IEN:   ien_d  = wd;
        OFS_ITYPE: ityp_d = wd;
        OFS_IPOL:  ipol_d = wd;
        OFS_IMASK: imsk_d = wd;
        default: ;
      endcase
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      ityp_q <= '0;
      ipol_q <= '0;
      imsk_q <= '0;
    end else begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      ien_q  <= ien_d;
      ityp_q <= ityp_d;
      ipol_q <= ipol_d;
      imsk_q <= imsk_d;
    end
  end

  // read mux
  always_comb begin
    unique case (bus_addr)
      OFS_DIR:   rd_v = dir_q;
      OFS_IN:    rd_v = smp;
      OFS_SET:   rd_v = out_q;
      OFS_CLR:   rd_v = out_q;
      OFS_IEN:   rd_v = ien_q;
      OFS_ITYPE: rd_v = ityp_q;
      OFS_IPOL:  rd_v = ipol_q;
      OFS_IPEND: rd_v = pend;
      OFS_IMASK: rd_v = imsk_q;
      default:   rd_v = '0;
    endcase
  end

  assign bus_rdata = BUS_W'(rd_v);
  assign pad_out   = out_q;
  assign pad_oe    = INV_DIR ? ~dir_q : dir_q;
  assign irq       = |(pend & imsk_q);

  // R3: set-register write forces the written ones high on the pads
  p_set_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_SET) |=> ((pad_out & $past(wd)) == $past(wd)));

  // R3: clear-register write forces the written ones low on the pads
  p_clr_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_CLR) |=> ((pad_out & $past(wd)) == '0));

  // R8: no request without some pin both enabled and unmasked
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(ien_q & imsk_q));

  // R10: bits above the implemented pins always read as zero
  p_high_bits_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> N) == '0);
endmodule

// File: tb/test_gpio_intc.sv
module test_gpio_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = 8'h00;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata, rdata_inv;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, out_inv, oe_inv;
  logic          irq, irq_inv;
  int            n_chk = 0;
  int            n_bad = 0;
  logic [31:0]   r;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_intc #(.PIN_CNT(NP), .INV_DIR(1'b0)) i_gpio_intc (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  gpio_intc #(.PIN_CNT(NP), .INV_DIR(1'b1)) i_gpio_intc_inv (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_inv),
    .pad_in(pad_in), .pad_out(out_inv), .pad_oe(oe_inv), .irq(irq_inv));

  localparam logic [7:0] A_DIR = 8'h00, A_IN = 8'h04, A_SET = 8'h0C, A_CLR = 8'h10,
    A_IEN = 8'h14, A_TYP = 8'h18, A_POL = 8'h1C, A_PND = 8'h20, A_MSK = 8'h24;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cfg(input logic [7:0] typ, input logic [7:0] pol,
                     input logic [7:0] msk, input logic [7:0] en);
    wr(A_IEN, 32'h0);
    wr(A_TYP, {24'h0, typ});
    wr(A_POL, {24'h0, pol});
    wr(A_MSK, {24'h0, msk});
    wr(A_PND, 32'hFF);
    wr(A_IEN, {24'h0, en});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] m;
    logic [7:0] old;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state, R2 offsets
    begin
      logic [7:0] offs [9] = '{A_DIR, A_IN, A_SET, A_CLR, A_IEN, A_TYP, A_POL, A_PND, A_MSK};
      for (int k = 0; k < 9; k++) begin
        rd(offs[k], r);
        chk("R1 reg after reset", r, 32'h0);
      end
    end
    chk("R1 pad_out", {24'h0, pad_out}, 32'h0);
    chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    chk("R1 pad_oe inverted", {24'h0, oe_inv}, 32'hFF);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R3 set/clear sweep
    m = '0;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a, b;
      a = 8'((k * 37 + 5) & 255);
      b = 8'((k * 53 + 9) & 255);
      wr(A_SET, {24'h0, a});
      m = m | a;
      chk("R3 pad_out after set", {24'h0, pad_out}, {24'h0, m});
      rd(A_SET, r);
      chk("R3 set readback", r, {24'h0, m});
      wr(A_CLR, {24'h0, b});
      m = m & ~b;
      rd(A_CLR, r);
      chk("R3 clear readback", r, {24'h0, m});
    end
    // R10 high bits ignored
    wr(A_SET, 32'hFFFF_FF00);
    rd(A_SET, r);
    chk("R10 high set bits ignored", r, {24'h0, m});
    wr(A_SET, 32'hFFFF_FFFF);
    rd(A_SET, r);
    chk("R10 readback width", r, 32'hFF);
    wr(A_CLR, 32'hFFFF_FFFF);
    chk("R3 clear all", {24'h0, pad_out}, 32'h0);

    // R4 direction
    for (int k = 0; k < 9; k++) begin
      logic [7:0] d;
      d = 8'((k * 29 + 3) & 255);
      wr(A_DIR, {24'hABCDEF, d});
      chk("R4 pad_oe", {24'h0, pad_oe}, {24'h0, d});
      chk("R4 pad_oe inverted", {24'h0, oe_inv}, {24'h0, ~d});
      rd(A_DIR, r);
      chk("R10 dir readback", r, {24'h0, d});
    end

    // R5 input synchronizer latency
    old = '0;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v;
      v = 8'((k * 71 + 1) & 255);
      pad_in = v;
      step(1);
      rd(A_IN, r);
      chk("R5 input after one edge", r, {24'h0, old});
      step(1);
      rd(A_IN, r);
      chk("R5 input after two edges", r, {24'h0, v});
      old = v;
    end

    // R6, R8 level detection per pin and polarity
    for (int i = 0; i < NP; i++) begin
      for (int p = 0; p < 2; p++) begin
        logic [7:0] bit_i;
        bit_i = 8'(1 << i);
        pad_in = (p == 1) ? 8'h00 : 8'hFF;
        step(3);
        cfg(8'hFF, (p == 1) ? 8'hFF : 8'h00, bit_i, bit_i);
        rd(A_PND, r);
        chk("R6 level inactive", r, 32'h0);
        chk("R8 irq idle", {31'h0, irq}, 32'h0);
        pad_in[i] = p[0];
        step(3);
        rd(A_PND, r);
        chk("R6 level active", r, {24'h0, bit_i});
        chk("R8 irq on level", {31'h0, irq}, 32'h1);
        wr(A_MSK, 32'h0);
        chk("R8 masked", {31'h0, irq}, 32'h0);
        rd(A_PND, r);
        chk("R8 pending despite mask", r, {24'h0, bit_i});
        wr(A_MSK, {24'h0, bit_i});
        wr(A_IEN, 32'h0);
        chk("R8 disabled no irq", {31'h0, irq}, 32'h0);
        rd(A_PND, r);
        chk("R6 disabled no pending", r, 32'h0);
        wr(A_IEN, {24'h0, bit_i});
        pad_in[i] = ~p[0];
        step(3);
        rd(A_PND, r);
        chk("R6 level released", r, 32'h0);
      end
    end

    // R7 edge detection per pin and polarity
    for (int i = 0; i < NP; i++) begin
      for (int p = 0; p < 2; p++) begin
        logic [7:0] bit_i;
        bit_i = 8'(1 << i);
        pad_in = (p == 1) ? 8'h00 : 8'hFF;
        step(3);
        cfg(8'h00, (p == 1) ? 8'hFF : 8'h00, bit_i, bit_i);
        rd(A_PND, r);
        chk("R7 edge idle", r, 32'h0);
        pad_in[i] = p[0];
        step(3);
        rd(A_PND, r);
        chk("R7 edge latched", r, {24'h0, bit_i});
        chk("R8 irq on edge", {31'h0, irq}, 32'h1);
        pad_in[i] = ~p[0];
        step(3);
        rd(A_PND, r);
        chk("R7 edge held", r, {24'h0, bit_i});
        wr(A_PND, {24'h0, bit_i});
        rd(A_PND, r);
        chk("R7 edge acknowledged", r, 32'h0);
        chk("R7 irq after ack", {31'h0, irq}, 32'h0);
        step(3);
        rd(A_PND, r);
        chk("R7 opposite edge ignored", r, 32'h0);
      end
    end

    // R9 edge while disabled is not recorded
    pad_in = 8'h00;
    step(3);
    cfg(8'h00, 8'hFF, 8'hFF, 8'h00);
    pad_in = 8'hFF;
    step(3);
    wr(A_IEN, 32'hFF);
    rd(A_PND, r);
    chk("R9 edge while disabled", r, 32'h0);
    chk("R9 irq after enable", {31'h0, irq}, 32'h0);

    // R9 latched edge dropped by disable
    pad_in = 8'h00;
    step(3);
    pad_in = 8'hFF;
    step(3);
    rd(A_PND, r);
    chk("R9 edges latched", r, 32'hFF);
    wr(A_IEN, 32'h0);
    wr(A_IEN, 32'hFF);
    rd(A_PND, r);
    chk("R9 disable drops latch", r, 32'h0);

    // R9 reconfiguration with steady input
    wr(A_POL, 32'h00);
    wr(A_POL, 32'hFF);
    wr(A_POL, 32'h00);
    wr(A_TYP, 32'hFF);
    wr(A_TYP, 32'h00);
    step(3);
    rd(A_PND, r);
    chk("R9 reconfig no edge", r, 32'h0);
    chk("R9 reconfig no irq", {31'h0, irq}, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule